// File: doc/BRIEF.md
# Processor sleep and wakeup controller

This block decides when a processor core stops issuing instructions and when it resumes. There are three ways to ask for sleep. A wait-for-interrupt request sleeps unconditionally. A wait-for-event request sleeps only when a sticky one-bit event latch is empty. A handler-return event sleeps automatically when the sleep-on-exit bit is set. The deep-sleep select bit is captured on entry and reported as the sleep depth for as long as the core sleeps.

While asleep, the block watches two things: the pending exception, whose priority it compares against the current execution priority, and a debug wake request. When either one ends sleep, the block raises a one-cycle wake pulse. A take-exception flag comes with the pulse and tells the core whether the pending handler should actually run. With interrupts masked, the core wakes but the handler is held back, so restore code can run first. The event latch is filled by the external event input, by an exception newly becoming pending, and by debug requests.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: After reset the block is awake, `wakePulse`, `takeExc` and `sleepDeep` are 0, and the event latch is empty, so a first wait-for-event request puts the core to sleep.
- R2: A `wfiReq` pulse while running sets `sleeping` on the next cycle, whatever the event latch holds.
- R3: A `wfeReq` pulse while running with an empty event latch and no simultaneous set source sets `sleeping` on the next cycle.
- R4: A `wfeReq` pulse while running with the event latch full leaves `sleeping` low and empties the latch, so the next `wfeReq` sleeps.
- R5: The event latch is filled by `evtIn`, by `dbgWake`, and by a 0-to-1 change of `excPend`. A set source in the same cycle as a `wfeReq` prevents sleep, and the set is consumed by that request.
- R6: A `handlerRet` pulse sleeps the core on the next cycle when `sleepOnExit` is 1. When `sleepOnExit` is 0 it has no effect.
- R7: `sleepDeep` equals the `deepSel` value present on the entry cycle. It holds while sleeping even if `deepSel` changes, and it reads 0 while awake.
- R8: A pending exception wakes the core only when `{0,excPrio}` is numerically lower (higher priority) than `curPrio`. An equal or larger value does not wake. A `curPrio` of 16 means no active exception and ranks below every real priority.
- R9: A wake raises `wakePulse` for exactly one cycle. `sleeping` falls in that same cycle. `takeExc` is high in that cycle when a qualifying exception woke the core with `primask` 0.
- R10: With `primask`=1 and `faultmask`=0, a qualifying exception still wakes the core but `takeExc` stays 0. With `faultmask`=1, exceptions do not wake the core.
- R11: `dbgWake` ends sleep with `takeExc` 0, and a later request puts the core back to sleep.
- R12: Sleep requests present during the wake-pulse cycle are ignored. They neither enter sleep nor consume the event latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wfiReq | input | 1 | Wait-for-interrupt request pulse |
| wfeReq | input | 1 | Wait-for-event request pulse |
| handlerRet | input | 1 | Pulse when a handler returns to thread level |
| deepSel | input | 1 | Selects deep (1) or light (0) sleep |
| sleepOnExit | input | 1 | Enables automatic sleep on handler return |
| primask | input | 1 | Interrupt mask bit |
| faultmask | input | 1 | Fault mask bit |
| excPend | input | 1 | A pending exception is valid |
| excPrio | input | 4 | Priority of the pending exception (lower value = higher priority) |
| curPrio | input | 5 | Current execution priority; 16 = no active exception |
| evtIn | input | 1 | External event |
| dbgWake | input | 1 | Debug wake request |
| sleeping | output | 1 | Core is asleep |
| sleepDeep | output | 1 | Depth of the current sleep |
| wakePulse | output | 1 | One-cycle wake indication |
| takeExc | output | 1 | Pending handler should run (valid with wakePulse) |

## Verification
The bench targets the event latch edge cases first. It checks a set that arrives in the same cycle as a wait-for-event request: a design that let sleep win would stop the core with an event outstanding. It checks that a full latch is emptied by the request that finds it full: a design that did not clear it would never sleep on wait-for-event again. Priority is probed at equal, lower and higher values and at the no-active-exception level. An off-by-one compare would wake on equal priority. A masked wake is checked for a low take flag, because a design that dispatched here would skip the restore window. Requests during the wake pulse are checked for having no effect, because a design that accepted them would fall straight back asleep.

// File: rtl/sleep_wake_pkg.sv
`timescale 1ns/1ps
package sleep_wake_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_WAKE  = 2'd2
  } swState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic consumeEv;   // empty the event latch
    logic latchDepth;  // capture sleep depth on entry
    logic latchTake;   // capture dispatch decision on wake
  } swStrobe_t;
endpackage

// File: rtl/swc_datapath.sv
`timescale 1ns/1ps
module swc_datapath
  import sleep_wake_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  swStrobe_t         strobe,
  input  logic              evtIn,
  input  logic              dbgWake,
  input  logic              excPend,
  input  logic [PRIO_W-1:0] excPrio,
  input  logic [PRIO_W:0]   curPrio,
  input  logic              primask,
  input  logic              faultmask,
  input  logic              deepSel,
  output logic              evAvail,
  output logic              wakeCond,
  output logic              depthQ,
  output logic              takeQ
);
  logic evReg;
  logic excPendQ;
  logic setNow;
  logic prioWins;
  logic excWake;
  logic takeCond;

  // sources that fill the event latch this cycle
  assign setNow   = evtIn | dbgWake | (excPend & ~excPendQ);
  assign evAvail  = evReg | setNow;

  // numerically lower value ranks higher; curPrio has one extra level
  assign prioWins = excPend && ({1'b0, excPrio} < curPrio);
  assign excWake  = prioWins & ~faultmask;
  assign wakeCond = dbgWake | excWake;
  assign takeCond = excWake & ~primask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evReg    <= 1'b0;
      excPendQ <= 1'b0;
      depthQ   <= 1'b0;
      takeQ    <= 1'b0;
    end else begin
      excPendQ <= excPend;
      if (strobe.consumeEv) evReg <= 1'b0;
      else                  evReg <= evReg | setNow;
      if (strobe.latchDepth) depthQ <= deepSel;
      takeQ <= strobe.latchTake & takeCond;
    end
  end

  // R4: a consumed event leaves the latch empty on the next cycle
  assert_ev_consumed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.consumeEv |=> !evReg);

  // R5: a set without consumption is remembered
  assert_ev_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (setNow && !strobe.consumeEv) |=> evReg);

  // R7: depth only changes on an entry strobe
  assert_depth_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.latchDepth |=> $stable(depthQ));
endmodule

// File: rtl/swc_ctrl.sv
`timescale 1ns/1ps
module swc_ctrl
  import sleep_wake_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wfiReq,
  input  logic      wfeReq,
  input  logic      handlerRet,
  input  logic      sleepOnExit,
  input  logic      evAvail,
  input  logic      wakeCond,
  output swStrobe_t strobe,
  output logic      sleeping,
  output logic      wakePulse
);
  swState_t stateQ, stateD;
  logic     enterReq;

  assign enterReq = wfiReq | (wfeReq & ~evAvail) | (handlerRet & sleepOnExit);

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_RUN: begin
        strobe.consumeEv = wfeReq & evAvail;
        if (enterReq) begin
          stateD            = ST_SLEEP;
          strobe.latchDepth = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (wakeCond) begin
          stateD           = ST_WAKE;
          strobe.latchTake = 1'b1;
        end
      end
      ST_WAKE: stateD = ST_RUN;
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= ST_RUN;
    else        stateQ <= stateD;
  end

  assign sleeping  = (stateQ == ST_SLEEP);
  assign wakePulse = (stateQ == ST_WAKE);

  // R2: a wait-for-interrupt while running always sleeps
  assert_wfi_sleeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ == ST_RUN && wfiReq) |=> sleeping);

  // R8: without a wake condition sleep persists
  assert_sleep_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sleeping && !wakeCond) |=> sleeping);

  // R9: wake pulse is single-cycle and exclusive with sleeping
  assert_wake_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wakePulse |=> !wakePulse);
  assert_wake_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sleeping && wakePulse));
  assert_wake_from_sleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wakePulse) |-> $past(sleeping));

  // R12: the cycle after a wake pulse is always awake
  assert_wake_ignores_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wakePulse |=> !sleeping);
endmodule

// File: rtl/sleep_wake_ctrl.sv
`timescale 1ns/1ps
module sleep_wake_ctrl
  import sleep_wake_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wfiReq,
  input  logic              wfeReq,
  input  logic              handlerRet,
  input  logic              deepSel,
  input  logic              sleepOnExit,
  input  logic              primask,
  input  logic              faultmask,
  input  logic              excPend,
  input  logic [PRIO_W-1:0] excPrio,
  input  logic [PRIO_W:0]   curPrio,
  input  logic              evtIn,
  input  logic              dbgWake,
  output logic              sleeping,
  output logic              sleepDeep,
  output logic              wakePulse,
  output logic              takeExc
);
  swStrobe_t strobe;
  logic      evAvail;
  logic      wakeCond;
  logic      depthQ;
  logic      takeQ;

  swc_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wfiReq     (wfiReq),
    .wfeReq     (wfeReq),
    .handlerRet (handlerRet),
    .sleepOnExit(sleepOnExit),
    .evAvail    (evAvail),
    .wakeCond   (wakeCond),
    .strobe     (strobe),
    .sleeping   (sleeping),
    .wakePulse  (wakePulse)
  );

  swc_datapath #(.PRIO_W(PRIO_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .evtIn     (evtIn),
    .dbgWake   (dbgWake),
    .excPend   (excPend),
    .excPrio   (excPrio),
    .curPrio   (curPrio),
    .primask   (primask),
    .faultmask (faultmask),
    .deepSel   (deepSel),
    .evAvail   (evAvail),
    .wakeCond  (wakeCond),
    .depthQ    (depthQ),
    .takeQ     (takeQ)
  );

  assign sleepDeep = depthQ & sleeping;
  assign takeExc   = takeQ;

  // R10: dispatch is only ever signalled together with a wake
  assert_take_in_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    takeExc |-> wakePulse);
endmodule

// File: tb/sleep_wake_ctrl_test.sv
`timescale 1ns/1ps
module sleep_wake_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wfiReq = 0, wfeReq = 0, handlerRet = 0;
  logic       deepSel = 0, sleepOnExit = 0, primask = 0, faultmask = 0;
  logic       excPend = 0;
  logic [3:0] excPrio = 4'd0;
  logic [4:0] curPrio = 5'd16;
  logic       evtIn = 0, dbgWake = 0;
  logic       sleeping, sleepDeep, wakePulse, takeExc;

  int  nCmp = 0;
  int  nBad = 0;
  bit  done = 0;

  always #2.5 clk = ~clk;

  sleep_wake_ctrl uut (
    .clk(clk), .rst_n(rst_n), .wfiReq(wfiReq), .wfeReq(wfeReq),
    .handlerRet(handlerRet), .deepSel(deepSel), .sleepOnExit(sleepOnExit),
    .primask(primask), .faultmask(faultmask), .excPend(excPend),
    .excPrio(excPrio), .curPrio(curPrio), .evtIn(evtIn), .dbgWake(dbgWake),
    .sleeping(sleeping), .sleepDeep(sleepDeep), .wakePulse(wakePulse),
    .takeExc(takeExc)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic dbgPulse();
    dbgWake = 1; step(); dbgWake = 0;
  endtask

  // leave the core awake with the event latch empty
  task automatic clearEv();
    wfeReq = 1; step(); wfeReq = 0;
    if (sleeping) begin
      dbgPulse(); step();
      wfeReq = 1; step(); wfeReq = 0;
    end
  endtask

  task automatic t_reset();
    rst_n = 0; step(); step();
    rst_n = 1; step();
    chk("R1 sleeping", sleeping, 1'b0);
    chk("R1 wakePulse", wakePulse, 1'b0);
    chk("R1 takeExc", takeExc, 1'b0);
    chk("R1 sleepDeep", sleepDeep, 1'b0);
    wfeReq = 1; step(); wfeReq = 0;
    chk("R1 R3 first wfe sleeps", sleeping, 1'b1);
    dbgPulse();
    chk("R11 debug wake pulse", wakePulse, 1'b1);
    chk("R11 sleeping falls", sleeping, 1'b0);
    chk("R11 no dispatch", takeExc, 1'b0);
    step();
    chk("R9 pulse one cycle", wakePulse, 1'b0);
    // latch is full from debug; wfi still sleeps
    wfiReq = 1; step(); wfiReq = 0;
    chk("R2 R11 wfi re-enters sleep", sleeping, 1'b1);
    dbgPulse(); step();
  endtask

  task automatic t_wfeEvent();
    wfeReq = 1; step(); wfeReq = 0;
    chk("R4 full latch blocks sleep", sleeping, 1'b0);
    wfeReq = 1; step(); wfeReq = 0;
    chk("R4 latch cleared, sleeps", sleeping, 1'b1);
    dbgPulse(); step(); clearEv();
  endtask

  task automatic t_evtSources();
    evtIn = 1; step(); evtIn = 0;
    wfeReq = 1; step(); wfeReq = 0;
    chk("R5 evtIn fills latch", sleeping, 1'b0);
    evtIn = 1; wfeReq = 1; step(); evtIn = 0; wfeReq = 0;
    chk("R5 same-cycle set wins", sleeping, 1'b0);
    wfeReq = 1; step(); wfeReq = 0;
    chk("R5 same-cycle set consumed", sleeping, 1'b1);
    dbgPulse(); step(); clearEv();
    curPrio = 5'd2; excPrio = 4'd7; excPend = 1; step(); excPend = 0; step();
    wfeReq = 1; step(); wfeReq = 0;
    chk("R5 new pending exception fills latch", sleeping, 1'b0);
    curPrio = 5'd16;
    clearEv();
  endtask

  task automatic t_soe();
    sleepOnExit = 0; handlerRet = 1; step(); handlerRet = 0;
    chk("R6 return without sleep-on-exit", sleeping, 1'b0);
    sleepOnExit = 1; handlerRet = 1; step(); handlerRet = 0;
    chk("R6 return with sleep-on-exit", sleeping, 1'b1);
    sleepOnExit = 0;
    dbgPulse(); step(); clearEv();
  endtask

  task automatic t_depth();
    deepSel = 1; wfiReq = 1; step(); wfiReq = 0;
    chk("R7 deep captured", sleepDeep, 1'b1);
    deepSel = 0; step();
    chk("R7 deep held", sleepDeep, 1'b1);
    dbgPulse();
    chk("R7 depth low when awake", sleepDeep, 1'b0);
    step();
    wfiReq = 1; step(); wfiReq = 0;
    chk("R7 light captured", sleepDeep, 1'b0);
    dbgPulse(); step(); clearEv();
  endtask

  task automatic t_prio();
    curPrio = 5'd5;
    wfiReq = 1; step(); wfiReq = 0;
    excPrio = 4'd5; excPend = 1; step();
    chk("R8 equal priority no wake", sleeping, 1'b1);
    excPrio = 4'd6; step();
    chk("R8 lower priority no wake", wakePulse, 1'b0);
    excPrio = 4'd4; step();
    chk("R8 higher priority wakes", wakePulse, 1'b1);
    chk("R9 sleeping falls with pulse", sleeping, 1'b0);
    chk("R9 dispatch on exception wake", takeExc, 1'b1);
    excPend = 0; step();
    chk("R9 pulse ends", wakePulse, 1'b0);
    chk("R9 dispatch ends", takeExc, 1'b0);
    curPrio = 5'd16; clearEv();
    wfiReq = 1; step(); wfiReq = 0;
    excPrio = 4'd15; excPend = 1; step();
    chk("R8 lowest priority beats no-active", wakePulse, 1'b1);
    excPend = 0; step(); clearEv();
  endtask

  task automatic t_mask();
    primask = 1;
    wfiReq = 1; step(); wfiReq = 0;
    excPrio = 4'd2; excPend = 1; step();
    chk("R10 masked exception wakes", wakePulse, 1'b1);
    chk("R10 masked no dispatch", takeExc, 1'b0);
    excPend = 0; step(); clearEv();
    faultmask = 1;
    wfiReq = 1; step(); wfiReq = 0;
    excPend = 1; step(); step();
    chk("R10 fault mask blocks wake", sleeping, 1'b1);
    excPend = 0; dbgPulse(); step();
    primask = 0; faultmask = 0; clearEv();
  endtask

  task automatic t_ignore();
    wfiReq = 1; step(); wfiReq = 0;
    dbgPulse();
    chk("R12 in wake pulse", wakePulse, 1'b1);
    wfiReq = 1; wfeReq = 1; step(); wfiReq = 0; wfeReq = 0;
    chk("R12 request during pulse ignored", sleeping, 1'b0);
    step();
    chk("R12 still awake", sleeping, 1'b0);
    // latch filled by debug must survive the ignored wfe
    wfeReq = 1; step(); wfeReq = 0;
    chk("R12 latch not consumed during pulse", sleeping, 1'b0);
  endtask

  initial begin
    t_reset();
    t_wfeEvent();
    t_evtSources();
    t_soe();
    t_depth();
    t_prio();
    t_mask();
    t_ignore();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule